// File: doc/BRIEF.md
# Dual Data Pointer Register Bank

This block keeps two 16-bit data pointers and a pointer-select register for a byte-oriented CPU core. Software reaches every byte of the bank through a small register bus: an 8-bit address, a write strobe, write data and combinational read data. The CPU datapath sees only the pointer that is currently selected. It uses that pointer as a memory address, and it can load it with a full 16-bit value or increment it.

A single select bit steers every datapath operation to one of the two pointers. Block copies therefore need only one register write to move from the source address to the destination address. The select register keeps just its lowest bit, so an increment of that register flips the selection. Its upper bits always read back as zero.

Top module: `dptr_bank`

## Requirements
- R1: After a synchronous active-low reset, both pointers and the select bit are zero, so `dp_addr` is 0000h and `dp_sel` is 0.
- R2: Pointer 0 low/high bytes are read and written at addresses 82h/83h; pointer 1 low/high bytes at 84h/85h; a byte write changes only the addressed byte.
- R3: Address 86h holds the select bit in bit 0; a write stores only bit 0 (02h selects pointer 0, 03h or FFh selects pointer 1) and reads return bits 7..1 as zero.
- R4: `dp_addr` always shows the selected pointer and `dp_sel` the select bit; with no bus write and no datapath command both hold their values.
- R5: A datapath load writes the full 16-bit `dp_load_val` into the selected pointer only; the other pointer is unchanged.
- R6: A datapath increment adds one to the selected pointer only, carrying from the low byte into the high byte and wrapping FFFFh to 0000h.
- R7: When a bus write and a datapath command hit the same pointer in one cycle, the bus write wins: the addressed byte takes the bus data and the other byte holds. A bus write to the unselected pointer does not block the command on the selected one.
- R8: When load and increment are both asserted, the load wins.
- R9: Addresses outside 82h..86h read as 00h, and writes to them change no pointer and no select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data (combinational) |
| dp_load | input | 1 | Load selected pointer from `dp_load_val` |
| dp_load_val | input | 16 | Value for a datapath load |
| dp_inc | input | 1 | Increment selected pointer |
| dp_addr | output | 16 | Currently selected pointer |
| dp_sel | output | 1 | Current select bit |

## Verification
The bench targets the carry from low byte into high byte (00FFh) and the full wrap (FFFFh). A broken carry chain leaves 0000h after 00FFh, and a saturating counter sticks at FFFFh. It writes 02h and FFh to the select register: a design that keeps more than bit 0 reads back nonzero upper bits or picks the wrong pointer. Same-cycle collisions between bus writes and datapath commands are driven on both the selected and the unselected pointer. A wrong priority loses the byte that was written, corrupts the other byte, or drops the increment on the other pointer. Reads and writes to neighbouring unmapped addresses catch address decode that is too wide.

// File: rtl/dptr_pkg.sv
// Package: shared command encoding for the data pointer bank.
// Assumes: consumers import it; no state lives here.
package dptr_pkg;

    // Datapath command delivered to one pointer cell per cycle.
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_INC  = 2'd2
    } dp_cmd_e;

    // Resolve raw datapath strobes into one command; load outranks increment.
    function automatic dp_cmd_e resolve_cmd(input logic load, input logic inc);
        if (load)
            return CMD_LOAD;
        else if (inc)
            return CMD_INC;
        else
            return CMD_IDLE;
    endfunction

endpackage

// File: rtl/dptr_cell.sv
// Module: one multi-byte pointer register with byte-wide bus access.
// Does: byte writes from the register bus, full loads and increments
//       from the datapath, and a byte read port.
// Assumes: bus writes outrank datapath commands; the bytes sit at
//          BASE, BASE+1, ... with the least significant byte first.
module dptr_cell
    import dptr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int BYTES  = 2,
    parameter logic [ADDR_W-1:0] BASE = 8'h82,
    localparam int PTR_W = DATA_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  dp_cmd_e           cmd,
    input  logic [PTR_W-1:0]  load_val,
    output logic [PTR_W-1:0]  ptr_q,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_byte
);

    logic [BYTES-1:0] byte_hit;
    logic [BYTES-1:0] byte_wr;
    logic             any_wr;

    // Per-byte address decode.
    for (genvar b = 0; b < BYTES; b++) begin : g_dec
        localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(BASE + b);
        assign byte_hit[b] = (bus_addr == BYTE_ADDR);
        assign byte_wr[b]  = bus_we && byte_hit[b];
    end

    assign any_wr = |byte_wr;
    assign rd_hit = |byte_hit;

    // Pointer storage: bus bytes first, then load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (any_wr) begin
            for (int b = 0; b < BYTES; b++) begin
                if (byte_wr[b])
                    ptr_q[b*DATA_W +: DATA_W] <= bus_wdata;
            end
        end else begin
            case (cmd)
                CMD_LOAD: ptr_q <= load_val;
                CMD_INC:  ptr_q <= ptr_q + PTR_W'(1);
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

    // Read-side byte select; zero when no byte matches.
    always_comb begin
        rd_byte = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (byte_hit[b])
                rd_byte = ptr_q[b*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/dptr_selreg.sv
// Module: pointer-select register.
// Does: keeps only the low SEL_W bits of a bus write and reads back
//       zero-extended.
// Assumes: the pointer count is a power of two, so every stored code
//          names a real pointer.
module dptr_selreg #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 1,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h86
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [SEL_W-1:0]  sel_q,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_byte
);

    assign rd_hit = (bus_addr == SEL_ADDR);

    // Select storage: low bits of a matching write only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_we && rd_hit)
            sel_q <= bus_wdata[SEL_W-1:0];
    end

    // Zero-extended read value.
    always_comb begin
        rd_byte = '0;
        rd_byte[SEL_W-1:0] = sel_q;
    end

endmodule

// File: rtl/dptr_rdmux.sv
// Module: read-data combiner for the register bus.
// Does: AND-OR merges N byte sources by their hit flags.
// Assumes: at most one hit is active; no hit yields zero.
module dptr_rdmux #(
    parameter int DATA_W = 8,
    parameter int N_SRC  = 3
) (
    input  logic [N_SRC-1:0]  hit,
    input  logic [DATA_W-1:0] src [N_SRC],
    output logic [DATA_W-1:0] rdata
);

    // OR of the gated sources.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_SRC; i++) begin
            rdata = rdata | (hit[i] ? src[i] : '0);
        end
    end

endmodule

// File: rtl/dptr_bank.sv
// Module: dual data pointer register bank (top).
// Does: holds NUM_PTR pointers and a select register on a byte bus and
//       steers datapath load/increment to the selected pointer, whose
//       value it presents as dp_addr.
// Assumes: pointers are packed PTR_BYTES apart from DP_BASE; a select
//          change takes effect on the cycle after its bus write.
module dptr_bank
    import dptr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int NUM_PTR   = 2,
    parameter int PTR_BYTES = 2,
    parameter logic [ADDR_W-1:0] DP_BASE  = 8'h82,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h86,
    localparam int PTR_W = DATA_W * PTR_BYTES,
    localparam int SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_we,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              dp_load,
    input  logic [PTR_W-1:0]  dp_load_val,
    input  logic              dp_inc,
    output logic [PTR_W-1:0]  dp_addr,
    output logic [SEL_W-1:0]  dp_sel
);

    localparam int N_SRC = NUM_PTR + 1;

    dp_cmd_e           req_cmd;
    logic [PTR_W-1:0]  ptr_val [NUM_PTR];
    logic [N_SRC-1:0]  rd_hit;
    logic [DATA_W-1:0] rd_src  [N_SRC];

    // Raw strobes to a single prioritised command.
    assign req_cmd = resolve_cmd(dp_load, dp_inc);

    dptr_selreg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W),
        .SEL_ADDR (SEL_ADDR)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (sfr_addr),
        .bus_we    (sfr_we),
        .bus_wdata (sfr_wdata),
        .sel_q     (dp_sel),
        .rd_hit    (rd_hit[NUM_PTR]),
        .rd_byte   (rd_src[NUM_PTR])
    );

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        localparam logic [ADDR_W-1:0] CELL_BASE = ADDR_W'(DP_BASE + i * PTR_BYTES);
        dp_cmd_e cell_cmd;

        // Only the selected cell sees the datapath command.
        assign cell_cmd = (dp_sel == SEL_W'(i)) ? req_cmd : CMD_IDLE;

        dptr_cell #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .BYTES  (PTR_BYTES),
            .BASE   (CELL_BASE)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_addr  (sfr_addr),
            .bus_we    (sfr_we),
            .bus_wdata (sfr_wdata),
            .cmd       (cell_cmd),
            .load_val  (dp_load_val),
            .ptr_q     (ptr_val[i]),
            .rd_hit    (rd_hit[i]),
            .rd_byte   (rd_src[i])
        );
    end

    // Selected pointer to the datapath.
    assign dp_addr = ptr_val[dp_sel];

    dptr_rdmux #(
        .DATA_W (DATA_W),
        .N_SRC  (N_SRC)
    ) u_rdmux (
        .hit   (rd_hit),
        .src   (rd_src),
        .rdata (sfr_rdata)
    );

endmodule

// File: rtl/dptr_bank_chk.sv
// Module: assertion checker for dptr_bank, bound to every instance.
// Does: checks reset, hold, load, increment, bus priority and read decode
//       from the top-level ports only.
// Assumes: default pointer layout relative to DP_BASE and SEL_ADDR.
module dptr_bank_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PTR_BYTES = 2,
    parameter int SEL_W     = 1,
    parameter logic [ADDR_W-1:0] DP_BASE  = 8'h82,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h86,
    localparam int PTR_W = DATA_W * PTR_BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_we,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic              dp_load,
    input logic [PTR_W-1:0]  dp_load_val,
    input logic              dp_inc,
    input logic [PTR_W-1:0]  dp_addr,
    input logic [SEL_W-1:0]  dp_sel
);

    logic [ADDR_W-1:0] sel_lo_addr;
    assign sel_lo_addr = ADDR_W'(DP_BASE + PTR_BYTES * dp_sel);

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (dp_addr == '0 && dp_sel == '0));

    p_selrd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == SEL_ADDR) |-> (sfr_rdata == DATA_W'(dp_sel)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sfr_we && !dp_load && !dp_inc) |=> ($stable(dp_addr) && $stable(dp_sel)));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sfr_we && dp_load) |=> (dp_addr == $past(dp_load_val)));

    p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sfr_we && dp_inc && !dp_load) |=> (dp_addr == PTR_W'($past(dp_addr) + 1'b1)));

    p_buswin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && sfr_addr == sel_lo_addr) |=>
        (dp_addr[DATA_W-1:0] == $past(sfr_wdata) &&
         dp_addr[PTR_W-1:DATA_W] == $past(dp_addr[PTR_W-1:DATA_W])));

    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr < DP_BASE || sfr_addr > SEL_ADDR) |-> (sfr_rdata == '0));

endmodule

bind dptr_bank dptr_bank_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PTR_BYTES (PTR_BYTES),
    .SEL_W     (SEL_W),
    .DP_BASE   (DP_BASE),
    .SEL_ADDR  (SEL_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sfr_addr    (sfr_addr),
    .sfr_we      (sfr_we),
    .sfr_wdata   (sfr_wdata),
    .sfr_rdata   (sfr_rdata),
    .dp_load     (dp_load),
    .dp_load_val (dp_load_val),
    .dp_inc      (dp_inc),
    .dp_addr     (dp_addr),
    .dp_sel      (dp_sel)
);

// File: tb/sim_dptr_bank.sv
`timescale 1ns/1ps
module sim_dptr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        dp_load = 1'b0;
    logic [15:0] dp_load_val = 16'h0000;
    logic        dp_inc = 1'b0;
    logic [15:0] dp_addr;
    logic [0:0]  dp_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dptr_bank u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sfr_addr    (sfr_addr),
        .sfr_we      (sfr_we),
        .sfr_wdata   (sfr_wdata),
        .sfr_rdata   (sfr_rdata),
        .dp_load     (dp_load),
        .dp_load_val (dp_load_val),
        .dp_inc      (dp_inc),
        .dp_addr     (dp_addr),
        .dp_sel      (dp_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock with the current inputs, then settle past the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        tick();
        sfr_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        sfr_addr = a;
        #0.5;
        chk(req, {24'h0, sfr_rdata}, {24'h0, exp});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        chk("R1 dp_addr", {16'h0, dp_addr}, 32'h0);
        chk("R1 dp_sel", {31'h0, dp_sel}, 32'h0);
        for (int a = 8'h82; a <= 8'h86; a++) rd_chk("R1 reg", 8'(a), 8'h00);
    endtask

    task automatic t_bus_rw();
        bus_wr(8'h82, 8'h34); bus_wr(8'h83, 8'h12);
        bus_wr(8'h84, 8'hCD); bus_wr(8'h85, 8'hAB);
        rd_chk("R2 p0 lo", 8'h82, 8'h34);
        rd_chk("R2 p0 hi", 8'h83, 8'h12);
        rd_chk("R2 p1 lo", 8'h84, 8'hCD);
        rd_chk("R2 p1 hi", 8'h85, 8'hAB);
        chk("R4 sel0 addr", {16'h0, dp_addr}, 32'h1234);
        bus_wr(8'h83, 8'h56);
        rd_chk("R2 byte only", 8'h82, 8'h34);
        chk("R2 merged", {16'h0, dp_addr}, 32'h5634);
        tick();
        chk("R4 hold", {16'h0, dp_addr}, 32'h5634);
    endtask

    task automatic t_select();
        bus_wr(8'h86, 8'hFF);
        rd_chk("R3 ff read", 8'h86, 8'h01);
        chk("R4 sel1 addr", {16'h0, dp_addr}, 32'hABCD);
        chk("R4 sel1", {31'h0, dp_sel}, 32'h1);
        bus_wr(8'h86, 8'h02);
        rd_chk("R3 02 read", 8'h86, 8'h00);
        chk("R3 02 sel", {16'h0, dp_addr}, 32'h5634);
        bus_wr(8'h86, 8'h03);
        rd_chk("R3 03 read", 8'h86, 8'h01);
        bus_wr(8'h86, 8'h02);
        chk("R3 toggle back", {31'h0, dp_sel}, 32'h0);
    endtask

    task automatic t_load();
        dp_load_val = 16'h5A5A; dp_load = 1'b1; tick(); dp_load = 1'b0;
        chk("R5 load p0", {16'h0, dp_addr}, 32'h5A5A);
        rd_chk("R5 p1 lo kept", 8'h84, 8'hCD);
        rd_chk("R5 p1 hi kept", 8'h85, 8'hAB);
        bus_wr(8'h86, 8'h01);
        dp_load_val = 16'h0F0F; dp_load = 1'b1; tick(); dp_load = 1'b0;
        chk("R5 load p1", {16'h0, dp_addr}, 32'h0F0F);
        rd_chk("R5 p0 kept", 8'h82, 8'h5A);
        bus_wr(8'h86, 8'h00);
    endtask

    task automatic t_inc();
        bus_wr(8'h82, 8'hFF); bus_wr(8'h83, 8'h00);
        dp_inc = 1'b1; tick(); dp_inc = 1'b0;
        chk("R6 carry", {16'h0, dp_addr}, 32'h0100);
        bus_wr(8'h82, 8'hFF); bus_wr(8'h83, 8'hFF);
        dp_inc = 1'b1; tick(); dp_inc = 1'b0;
        chk("R6 wrap", {16'h0, dp_addr}, 32'h0000);
        dp_inc = 1'b1; tick(); tick(); dp_inc = 1'b0;
        chk("R6 two steps", {16'h0, dp_addr}, 32'h0002);
        rd_chk("R6 p1 untouched", 8'h84, 8'h0F);
    endtask

    task automatic t_conflict();
        bus_wr(8'h82, 8'h34); bus_wr(8'h83, 8'h12);
        sfr_addr = 8'h82; sfr_wdata = 8'h77; sfr_we = 1'b1; dp_inc = 1'b1;
        tick(); sfr_we = 1'b0; dp_inc = 1'b0;
        chk("R7 wr beats inc", {16'h0, dp_addr}, 32'h1277);
        sfr_addr = 8'h83; sfr_wdata = 8'h99; sfr_we = 1'b1;
        dp_load_val = 16'hABCD; dp_load = 1'b1;
        tick(); sfr_we = 1'b0; dp_load = 1'b0;
        chk("R7 wr beats load", {16'h0, dp_addr}, 32'h9977);
        sfr_addr = 8'h84; sfr_wdata = 8'h11; sfr_we = 1'b1; dp_inc = 1'b1;
        tick(); sfr_we = 1'b0; dp_inc = 1'b0;
        chk("R7 other ptr inc", {16'h0, dp_addr}, 32'h9978);
        rd_chk("R7 other ptr wr", 8'h84, 8'h11);
    endtask

    task automatic t_prio();
        dp_load_val = 16'h2000; dp_load = 1'b1; dp_inc = 1'b1;
        tick(); dp_load = 1'b0; dp_inc = 1'b0;
        chk("R8 load beats inc", {16'h0, dp_addr}, 32'h2000);
    endtask

    task automatic t_unmapped();
        bus_wr(8'h81, 8'hFF); bus_wr(8'h87, 8'hFF); bus_wr(8'h00, 8'hFF);
        rd_chk("R9 81", 8'h81, 8'h00);
        rd_chk("R9 87", 8'h87, 8'h00);
        rd_chk("R9 FF", 8'hFF, 8'h00);
        chk("R9 ptr kept", {16'h0, dp_addr}, 32'h2000);
        chk("R9 sel kept", {31'h0, dp_sel}, 32'h0);
        rd_chk("R9 p1 kept", 8'h85, 8'h0F);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_bus_rw();
        t_select();
        t_load();
        t_inc();
        t_conflict();
        t_prio();
        t_unmapped();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule